// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers up to 32 level-style interrupt lines from peripherals and hands the most urgent one to a processor core. Each line has an enable bit, a pending bit and a 2-bit urgency level. A lower number means more urgent. A rising level on a line marks it pending. Among pending and enabled lines, the controller picks the most urgent one. It offers that line to the core as an entry request that carries the line number.

The core side is modelled by three handshake signals: the request with its vector, an acknowledge that starts the handler, and a return pulse that ends it. The block tracks the urgency of the running handler on a four-entry stack. Only a strictly more urgent line can interrupt a running handler. Two cases skip a dead cycle:
- A more urgent arrival replaces a vector that is still being offered.
- A return that leaves an eligible line pending presents that line on the very next cycle.

Software reaches the enable, pending and level fields through a plain write/read port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, no request is offered, the running level reads 4 (idle), and the enable, pending and level registers all read zero.
- R2: A line becomes pending only on a 0-to-1 change of its input. A line held high does not become pending again after its pending bit is cleared.
- R3: Register port layout. Address 0 sets enable bits and address 1 clears them (write 1 to act). Address 2 sets pending bits and address 3 clears them. Reads of 0 or 1 return the enable mask, and reads of 2 or 3 return the pending mask (bit i = line i). Address 4+k holds the levels of lines 16k..16k+15, with line i at bits 2*(i%16)+1:2*(i%16).
- R4: A pending line whose enable bit is clear is never offered.
- R5: Among eligible lines, the one with the lowest level value wins. Ties go to the lowest line number.
- R6: A rising input on an idle controller gives pending on the next clock edge and an entry request with that vector on the edge after.
- R7: An acknowledge while a request is offered clears that line's pending bit and drops the request on the next cycle. It also makes the running level equal to the offered line's level.
- R8: A line is offered only when its level value is strictly lower than the running level. Equal or less urgent lines wait.
- R9: While a request is offered but not yet acknowledged, a newly pending, more urgent line replaces the offered vector without the request dropping.
- R10: On a return pulse, if a line is eligible against the restored running level, the request is asserted on the very next cycle.
- R11: Running levels nest up to four deep. A return restores the level that was running before. A return while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_IRQ | Peripheral interrupt lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| entry_req_o | output | 1 | Entry request to the core |
| entry_vec_o | output | $clog2(NUM_IRQ) | Offered vector number |
| entry_ack_i | input | 1 | Core accepts the offered vector |
| exc_ret_i | input | 1 | Core returns from the current handler |
| run_prio_o | output | PRIO_W+1 | Running level (2**PRIO_W means idle) |

## Verification
The hardest situation to reach from the ports is a return that lands on a tie. Two lines of equal level must be pending while a handler of that same level runs, so both are held back. Then the return must pop straight into the lower-numbered one. The stimulus first nests a level-0 handler over a level-1 handler. It unwinds both levels. It then sets the pending bits of two level-1 lines by software while a level-1 handler runs. It checks that the request stays low, and that the return offers the lower-numbered line on the next cycle. The same chain also covers late-arrival replacement and a return while idle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int REG_AW = 4;
    localparam int REG_DW = 32;

    localparam logic [REG_AW-1:0] ADDR_EN_SET   = 4'd0;
    localparam logic [REG_AW-1:0] ADDR_EN_CLR   = 4'd1;
    localparam logic [REG_AW-1:0] ADDR_PEND_SET = 4'd2;
    localparam logic [REG_AW-1:0] ADDR_PEND_CLR = 4'd3;
    localparam int                ADDR_LVL_BASE = 4;

endpackage

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 2,
    localparam int IDW    = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]             cand_i,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
    output logic                           found_o,
    output logic [IDW-1:0]                 idx_o,
    output logic [PRIO_W-1:0]              prio_o
);

    // Strict compare keeps the lowest index on equal levels.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (cand_i[i] && (!found_o || (prio_i[i] < prio_o))) begin
                found_o = 1'b1;
                idx_o   = IDW'(i);
                prio_o  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
    parameter int PRIO_W = 2,
    parameter int DEPTH  = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int RPW   = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [PRIO_W-1:0] push_prio_i,
    input  logic              pop_i,
    output logic [RPW-1:0]    run_prio_o,
    output logic [RPW-1:0]    run_prio_next_o,
    output logic [CW-1:0]     depth_o
);

    localparam logic [RPW-1:0] IDLE_LVL = RPW'(1 << PRIO_W);

    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] ent;
        logic [CW-1:0]                cnt;
    } stk_t;

    stk_t s_d, s_q;

    function automatic logic [RPW-1:0] top_of(stk_t s);
        logic [RPW-1:0] r;
        r = IDLE_LVL;
        for (int k = 0; k < DEPTH; k++) begin
            if (k + 1 == int'(s.cnt)) r = {1'b0, s.ent[k]};
        end
        return r;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push_i && (int'(s_q.cnt) < DEPTH)) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (k == int'(s_q.cnt)) s_d.ent[k] = push_prio_i;
            end
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (pop_i && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_prio_o      = top_of(s_q);
    assign run_prio_next_o = top_of(s_d);
    assign depth_o         = s_q.cnt;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ     = 32,
    parameter int PRIO_W      = 2,
    parameter int STACK_DEPTH = 4,
    localparam int IDW        = $clog2(NUM_IRQ),
    localparam int RPW        = PRIO_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               reg_wr_i,
    input  logic [3:0]         reg_addr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               entry_req_o,
    output logic [IDW-1:0]     entry_vec_o,
    input  logic               entry_ack_i,
    input  logic               exc_ret_i,
    output logic [RPW-1:0]     run_prio_o
);

    localparam int PPW = REG_DW / PRIO_W;
    localparam int NPW = (NUM_IRQ + PPW - 1) / PPW;
    localparam int CW  = $clog2(STACK_DEPTH + 1);

    typedef struct packed {
        logic [NUM_IRQ-1:0]             irq_q;
        logic [NUM_IRQ-1:0]             en;
        logic [NUM_IRQ-1:0]             pend;
        logic [NUM_IRQ-1:0][PRIO_W-1:0] lvl;
        logic                           req;
        logic [IDW-1:0]                 vec;
        logic [PRIO_W-1:0]              oprio;
    } state_t;

    state_t s_d, s_q;

    logic              sel_found;
    logic [IDW-1:0]    sel_idx;
    logic [PRIO_W-1:0] sel_prio;
    logic              stk_push;
    logic              stk_pop;
    logic [RPW-1:0]    run_prio_next;
    logic [CW-1:0]     stk_depth;
    logic [PRIO_W-1:0] offer_prio;

    irq_prio_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_select (
        .cand_i  (s_q.pend & s_q.en),
        .prio_i  (s_q.lvl),
        .found_o (sel_found),
        .idx_o   (sel_idx),
        .prio_o  (sel_prio)
    );

    assign stk_push   = entry_ack_i && s_q.req;
    assign stk_pop    = exc_ret_i && !stk_push;
    assign offer_prio = s_q.oprio;

    irq_active_stack #(.PRIO_W(PRIO_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk             (clk),
        .rst_n           (rst_n),
        .push_i          (stk_push),
        .push_prio_i     (s_q.oprio),
        .pop_i           (stk_pop),
        .run_prio_o      (run_prio_o),
        .run_prio_next_o (run_prio_next),
        .depth_o         (stk_depth)
    );

    always_comb begin
        logic [NUM_IRQ-1:0] wmask, sw_set, sw_clr, ack_mask;
        s_d   = s_q;
        wmask = reg_wdata_i[NUM_IRQ-1:0];

        if (reg_wr_i && reg_addr_i == ADDR_EN_SET) s_d.en = s_q.en | wmask;
        if (reg_wr_i && reg_addr_i == ADDR_EN_CLR) s_d.en = s_q.en & ~wmask;

        sw_set = (reg_wr_i && reg_addr_i == ADDR_PEND_SET) ? wmask : '0;
        sw_clr = (reg_wr_i && reg_addr_i == ADDR_PEND_CLR) ? wmask : '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            ack_mask[i] = stk_push && (s_q.vec == IDW'(i));
        end
        // A fresh edge or software set outranks any clear in the same cycle.
        s_d.pend  = (s_q.pend & ~ack_mask & ~sw_clr) | (irq_i & ~s_q.irq_q) | sw_set;
        s_d.irq_q = irq_i;

        for (int i = 0; i < NUM_IRQ; i++) begin
            if (reg_wr_i && reg_addr_i == REG_AW'(ADDR_LVL_BASE + i / PPW)) begin
                s_d.lvl[i] = reg_wdata_i[(i % PPW) * PRIO_W +: PRIO_W];
            end
        end

        // Offer is judged against the level that holds after this cycle's
        // return, which gives tail-chaining and late-arrival replacement.
        if (stk_push) begin
            s_d.req = 1'b0;
        end else begin
            s_d.req = sel_found && ({1'b0, sel_prio} < run_prio_next);
            if (sel_found) begin
                s_d.vec   = sel_idx;
                s_d.oprio = sel_prio;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        logic [NPW*REG_DW-1:0] lvl_flat;
        lvl_flat = '0;
        for (int i = 0; i < NUM_IRQ; i++) lvl_flat[i*PRIO_W +: PRIO_W] = s_q.lvl[i];
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_EN_SET, ADDR_EN_CLR:     reg_rdata_o = REG_DW'(s_q.en);
            ADDR_PEND_SET, ADDR_PEND_CLR: reg_rdata_o = REG_DW'(s_q.pend);
            default: begin
                for (int k = 0; k < NPW; k++) begin
                    if (reg_addr_i == REG_AW'(ADDR_LVL_BASE + k)) begin
                        reg_rdata_o = lvl_flat[k*REG_DW +: REG_DW];
                    end
                end
            end
        endcase
    end

    assign entry_req_o = s_q.req;
    assign entry_vec_o = s_q.vec;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int PRIO_W      = 2,
    parameter int STACK_DEPTH = 4,
    localparam int CW         = $clog2(STACK_DEPTH + 1),
    localparam int RPW        = PRIO_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              entry_req_o,
    input logic              entry_ack_i,
    input logic              exc_ret_i,
    input logic [RPW-1:0]    run_prio_o,
    input logic [CW-1:0]     stk_depth,
    input logic              stk_push,
    input logic [PRIO_W-1:0] offer_prio
);

    assert_offer_outranks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        entry_req_o |-> ({1'b0, offer_prio} < run_prio_o));

    assert_req_drops_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req_o && entry_ack_i) |=> !entry_req_o);

    assert_ack_sets_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_req_o && entry_ack_i) |=> (run_prio_o == {1'b0, $past(offer_prio)}));

    assert_stack_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |-> (int'(stk_depth) < STACK_DEPTH));

    assert_return_restores_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ret_i && !(entry_req_o && entry_ack_i) && stk_depth != '0)
            |=> (run_prio_o > $past(run_prio_o)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .entry_req_o (entry_req_o),
    .entry_ack_i (entry_ack_i),
    .exc_ret_i   (exc_ret_i),
    .run_prio_o  (run_prio_o),
    .stk_depth   (stk_depth),
    .stk_push    (stk_push),
    .offer_prio  (offer_prio)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req;
    logic [4:0]  vec;
    logic        ack = 1'b0;
    logic        ret = 1'b0;
    logic [2:0]  rp;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        bit          is_rd;
        bit          req;
        logic [4:0]  vec;
        logic [2:0]  rp;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .entry_req_o (req),
        .entry_vec_o (vec),
        .entry_ack_i (ack),
        .exc_ret_i   (ret),
        .run_prio_o  (rp)
    );

    // Monitor: compares every queued expectation at the falling edge.
    always @(negedge clk) begin
        while (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (e.is_rd) begin
                if (reg_rdata !== e.data) begin
                    n_fail++;
                    $display("FAIL %s: rdata actual %h expected %h", e.tag, reg_rdata, e.data);
                end
            end else if (req !== e.req || rp !== e.rp || (e.req && vec !== e.vec)) begin
                n_fail++;
                $display("FAIL %s: req/vec/lvl actual %0d/%0d/%0d expected %0d/%0d/%0d",
                         e.tag, req, vec, rp, e.req, e.vec, e.rp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic exp_core(input bit r, input int v, input int l, input string tag);
        exp_t e;
        e.is_rd = 1'b0; e.req = r; e.vec = 5'(v); e.rp = 3'(l); e.data = '0; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic exp_rd(input int a, input logic [31:0] d, input string tag);
        exp_t e;
        reg_addr = 4'(a);
        e.is_rd = 1'b1; e.req = 1'b0; e.vec = '0; e.rp = '0; e.data = d; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_ret();
        ret = 1'b1; tick(); ret = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        exp_core(0, 0, 4, "R1 idle after reset");
        exp_rd(0, 32'h0, "R1 enable zero");
        exp_rd(2, 32'h0, "R1 pending zero");
        exp_rd(4, 32'h0, "R1 levels zero");

        // Register layout: enable lines 4..7; levels 4=2, 5=1, 6=1, 7=0
        wr(0, 32'hFF);
        wr(1, 32'h0F);
        exp_rd(0, 32'hF0, "R3 enable set/clear");
        exp_rd(1, 32'hF0, "R3 enable readable at 1");
        wr(4, 32'h1600);
        exp_rd(4, 32'h1600, "R3 level word 0");
        exp_rd(5, 32'h0, "R3 level word 1");

        // Software-pended disabled line 0
        wr(2, 32'h1);
        exp_rd(2, 32'h1, "R3 pending set");
        tick(); tick();
        exp_core(0, 0, 4, "R4 disabled line not offered");
        wr(3, 32'h1);
        exp_rd(3, 32'h0, "R3 pending clear");

        // Rising edge on line 4
        irq[4] = 1'b1;
        tick();
        exp_core(0, 0, 4, "R6 no request one edge after input");
        exp_rd(2, 32'h10, "R2 edge sets pending");
        tick();
        exp_core(1, 4, 4, "R6 request two edges after input");

        // Late arrival of more urgent line 5
        irq[5] = 1'b1;
        tick();
        exp_core(1, 4, 4, "R9 old vector held one cycle");
        tick();
        exp_core(1, 5, 4, "R9 vector replaced without drop");

        pulse_ack();
        exp_core(0, 0, 1, "R7 ack drops request, level 1");
        exp_rd(2, 32'h10, "R7 acked line pending cleared");
        tick();
        exp_core(0, 0, 1, "R8 less urgent line held back");

        irq[6] = 1'b1;
        tick(); tick();
        exp_core(0, 0, 1, "R8 equal level does not preempt");

        irq[7] = 1'b1;
        tick(); tick();
        exp_core(1, 7, 1, "R8 strictly more urgent preempts");
        pulse_ack();
        exp_core(0, 0, 0, "R11 nested level 0");

        pulse_ret();
        exp_core(0, 0, 1, "R11 return restores level 1");
        pulse_ret();
        exp_core(1, 6, 4, "R10 tail-chain to line 6 (R5 lower level wins)");
        pulse_ack();
        exp_core(0, 0, 1, "R7 level 1 after ack of 6");

        wr(2, 32'h60);
        tick();
        exp_core(0, 0, 1, "R8 sw-pended equal lines wait");
        pulse_ret();
        exp_core(1, 5, 4, "R5 tie goes to lower number, R10 chained");
        pulse_ack();
        exp_core(0, 0, 1, "R7 level 1 after ack of 5");
        pulse_ret();
        exp_core(1, 6, 4, "R10 chain to line 6");
        pulse_ack();
        exp_core(0, 0, 1, "R7 level 1 after ack of 6");
        pulse_ret();
        exp_core(1, 4, 4, "R10 chain to line 4");
        pulse_ack();
        exp_core(0, 0, 2, "R7 level 2 after ack of 4");
        pulse_ret();
        exp_core(0, 0, 4, "R2 held-high lines not re-pended");
        exp_rd(2, 32'h0, "R2 pending empty with inputs high");
        tick();
        pulse_ret();
        exp_core(0, 0, 4, "R11 return while idle ignored");
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule